// File: doc/BRIEF.md
# DMA Channel Completion and Escape Interrupt Logic

This block holds the status and interrupt state of one DMA channel. It keeps a transfer counter and a channel enable bit. It raises two level interrupt requests. The completion request fires when the counter runs down to zero. The escape request fires when the channel is stopped early by one of four abort causes, each of which software can enable on its own. Address generation and bus traffic belong to a neighbouring block. That block reports each finished transfer as a one-cycle `xfer_done` strobe, each channel start as an `activate` strobe, and each repeat-area overflow as a strobe.

Software uses a small register port. One control word holds the channel enable, the two interrupt enables and the four cause enables. One status word holds the two flags. A counter word can be loaded and read back. Writing 1 to the channel enable resumes the channel and clears both flags. Software can also clear a single flag by reading it as 1 and then writing 0 to it. Whenever a flag is set, the hardware drops the channel enable.

Top module: `dma_endirq_ctrl`

## Requirements
- R1: After a synchronous reset, the control word, the status word, the counter, `chan_en`, `irq_done` and `irq_esc` are all zero.
- R2: Each `xfer_done` strobe taken while the channel is enabled lowers the counter by one. The counter saturates at zero. A strobe taken while the channel is disabled leaves the counter unchanged.
- R3: A strobe that takes the counter from 1 to 0 sets the completion flag (status bit 0) and clears `chan_en` on the same edge.
- R4: `irq_done` equals the completion flag AND the completion interrupt enable (control bit 1). `irq_esc` equals the escape flag AND the escape interrupt enable (control bit 2). Both outputs are registered and move on the same edge as the flag or enable they follow.
- R5: An `activate` strobe while the channel is enabled, with `size_err` high and the size-error cause enable (control bit 3) set, sets the escape flag (status bit 1) and clears `chan_en`.
- R6: A 1-to-0 change of `blk_mode` arms a pending condition. The next `activate` strobe while the channel is enabled, with the block-reconfiguration cause enable (control bit 4) set, sets the escape flag and clears `chan_en`. Any enabled activation consumes the pending condition.
- R7: A `src_ovf` strobe with control bit 5 set, or a `dst_ovf` strobe with control bit 6 set, sets the escape flag and clears `chan_en`. These two causes are accepted whether or not the channel is enabled.
- R8: An abort cause whose enable bit is 0 leaves the escape flag and `chan_en` unchanged. An activation with no cause present also leaves them unchanged.
- R9: A control write with bit 0 set enables the channel and clears both flags.
- R10: Writing 0 to a status bit clears that flag only if the flag was read as 1 since its last clear. A write of 0 with no such read leaves the flag set.
- R11: When a flag's set condition occurs in the same cycle as a software clear or a resume write, the flag ends up set and `chan_en` ends up 0.
- R12: Register map. Address 0 is control: bit 0 enable, bit 1 completion IE, bit 2 escape IE, bits 6:3 cause enables (size error, block reconfiguration, source overflow, destination overflow). Address 1 is status: bit 0 completion, bit 1 escape. Address 2 is the counter. Address 3 reads 0. Read data is combinational from the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data |
| xfer_done | input | 1 | One-cycle strobe per finished transfer |
| activate | input | 1 | One-cycle channel activation strobe |
| size_err | input | 1 | Transfer-size error condition level |
| blk_mode | input | 1 | Block-size mode bit level |
| src_ovf | input | 1 | Source repeat-area overflow strobe |
| dst_ovf | input | 1 | Destination repeat-area overflow strobe |
| chan_en | output | 1 | Channel enable state |
| irq_done | output | 1 | Completion interrupt request |
| irq_esc | output | 1 | Escape interrupt request |

## Verification
The hardest situation to reach is a flag being set in the same cycle as a software clear. Normally the channel is disabled once a flag is set, so no new set condition can arise. The stimulus gets around this with the overflow causes, which are accepted while the channel is disabled. It arms the escape flag with a status read, then pulses `src_ovf` in the same cycle as a status write of 0. It then repeats the collision against a resume write. The block-reconfiguration cause needs its own three-step sequence: raise `blk_mode`, drop it, then activate.

// File: rtl/dma_endirq_pkg.sv
package dma_endirq_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_CNT  = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    localparam int CAUSE_N   = 4;
    localparam int CTRL_BITS = 3 + CAUSE_N;
    localparam int FLAG_N    = 2;

    localparam int FLAG_DONE = 0;
    localparam int FLAG_ESC  = 1;

    typedef struct packed {
        logic [CAUSE_N-1:0] cause_ie;
        logic               esc_ie;
        logic               done_ie;
        logic               en;
    } ctrl_t;

endpackage

// File: rtl/dma_endirq_count.sv
module dma_endirq_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             zero_hit
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = ld_val;
        end else if (dec && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt      = st_q.cnt;
    assign zero_hit = dec && !load && (st_q.cnt == CNT_W'(1));

    p_saturate_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == '0 && !load) |=> (st_q.cnt == '0));

    p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));

endmodule

// File: rtl/dma_endirq_cause.sv
module dma_endirq_cause
    import dma_endirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               activate,
    input  logic               chan_en,
    input  logic               size_err,
    input  logic               blk_mode,
    input  logic               src_ovf,
    input  logic               dst_ovf,
    input  logic [CAUSE_N-1:0] cause_ie,
    output logic               abort
);

    typedef struct packed {
        logic blk;
        logic pend;
    } cause_state_t;

    cause_state_t st_d, st_q;
    logic [CAUSE_N-1:0] raw;
    logic [CAUSE_N-1:0] gated;
    logic               take_act;
    logic               blk_fall;

    always_comb begin
        take_act = activate && chan_en;
        blk_fall = st_q.blk && !blk_mode;
        raw[0]   = take_act && size_err;
        raw[1]   = take_act && st_q.pend;
        raw[2]   = src_ovf;
        raw[3]   = dst_ovf;

        st_d     = st_q;
        st_d.blk = blk_mode;
        if (blk_fall)      st_d.pend = 1'b1;
        else if (take_act) st_d.pend = 1'b0;
    end

    for (genvar i = 0; i < CAUSE_N; i++) begin : g_gate
        assign gated[i] = raw[i] && cause_ie[i];
    end

    assign abort = |gated;

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    p_fall_arms_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q.blk && !blk_mode) |=> st_q.pend);

    p_abort_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
        abort |-> (cause_ie != '0));

endmodule

// File: rtl/dma_endirq_flag.sv
module dma_endirq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic resume,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic wbit,
    output logic flag,
    output logic flag_nxt
);

    typedef struct packed {
        logic flag;
        logic armed;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_hit && st_q.flag) st_d.armed = 1'b1;
        if (wr_hit) begin
            if (st_q.armed && !wbit) st_d.flag = 1'b0;
            st_d.armed = 1'b0;
        end
        if (resume) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b0;
        end
        if (set) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flag     = st_q.flag;
    assign flag_nxt = st_d.flag;

    p_clear_needs_read_r10: assert property (@(posedge clk) disable iff (rst)
        ($fell(st_q.flag) && !$past(resume)) |-> $past(st_q.armed));

    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
        set |=> st_q.flag);

endmodule

// File: rtl/dma_endirq_ctrl.sv
module dma_endirq_ctrl
    import dma_endirq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             xfer_done,
    input  logic             activate,
    input  logic             size_err,
    input  logic             blk_mode,
    input  logic             src_ovf,
    input  logic             dst_ovf,
    output logic             chan_en,
    output logic             irq_done,
    output logic             irq_esc
);

    localparam int PAD_W = CNT_W - CTRL_BITS;

    typedef struct packed {
        ctrl_t ctrl;
        logic  irq_done;
        logic  irq_esc;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              wr_ctrl, wr_stat, wr_cnt, rd_stat, resume;
    logic              dec, zero_hit, abort;
    logic [CNT_W-1:0]  cnt;
    logic [FLAG_N-1:0] flag_set, flag_q, flag_nxt;

    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
        wr_stat = reg_wr && (reg_addr == ADDR_STAT);
        wr_cnt  = reg_wr && (reg_addr == ADDR_CNT);
        rd_stat = reg_rd && (reg_addr == ADDR_STAT);
        resume  = wr_ctrl && reg_wdata[0];
        dec     = xfer_done && st_q.ctrl.en;
        flag_set[FLAG_DONE] = zero_hit;
        flag_set[FLAG_ESC]  = abort;
    end

    dma_endirq_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_cnt),
        .ld_val   (reg_wdata),
        .dec      (dec),
        .cnt      (cnt),
        .zero_hit (zero_hit)
    );

    dma_endirq_cause u_cause (
        .clk      (clk),
        .rst      (rst),
        .activate (activate),
        .chan_en  (st_q.ctrl.en),
        .size_err (size_err),
        .blk_mode (blk_mode),
        .src_ovf  (src_ovf),
        .dst_ovf  (dst_ovf),
        .cause_ie (st_q.ctrl.cause_ie),
        .abort    (abort)
    );

    for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
        dma_endirq_flag u_flag (
            .clk      (clk),
            .rst      (rst),
            .set      (flag_set[f]),
            .resume   (resume),
            .rd_hit   (rd_stat),
            .wr_hit   (wr_stat),
            .wbit     (reg_wdata[f]),
            .flag     (flag_q[f]),
            .flag_nxt (flag_nxt[f])
        );
    end

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) st_d.ctrl = reg_wdata[CTRL_BITS-1:0];
        if (|flag_set) st_d.ctrl.en = 1'b0;
        st_d.irq_done = flag_nxt[FLAG_DONE] && st_d.ctrl.done_ie;
        st_d.irq_esc  = flag_nxt[FLAG_ESC]  && st_d.ctrl.esc_ie;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = {{PAD_W{1'b0}}, st_q.ctrl};
            ADDR_STAT: reg_rdata = {{(CNT_W-FLAG_N){1'b0}}, flag_q};
            ADDR_CNT:  reg_rdata = cnt;
            default:   reg_rdata = '0;
        endcase
    end

    assign chan_en  = st_q.ctrl.en;
    assign irq_done = st_q.irq_done;
    assign irq_esc  = st_q.irq_esc;

    p_irq_level_r4: assert property (@(posedge clk) disable iff (rst)
        (irq_done == (flag_q[FLAG_DONE] && st_q.ctrl.done_ie)) &&
        (irq_esc  == (flag_q[FLAG_ESC]  && st_q.ctrl.esc_ie)));

    p_done_stops_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q[FLAG_DONE]) |-> !chan_en);

    p_esc_stops_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q[FLAG_ESC]) |-> !chan_en);

    p_resume_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (resume && !(|flag_set)) |=> (flag_q == '0) && chan_en);

endmodule

// File: tb/dma_endirq_ctrl_bench.sv
module dma_endirq_ctrl_bench;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]       reg_addr = '0;
    logic [CNT_W-1:0] reg_wdata = '0;
    logic [CNT_W-1:0] reg_rdata;
    logic             xfer_done = 1'b0, activate = 1'b0, size_err = 1'b0;
    logic             blk_mode = 1'b0, src_ovf = 1'b0, dst_ovf = 1'b0;
    logic             chan_en, irq_done, irq_esc;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dma_endirq_ctrl #(.CNT_W(CNT_W)) u_dma_endirq_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_done(xfer_done), .activate(activate), .size_err(size_err),
        .blk_mode(blk_mode), .src_ovf(src_ovf), .dst_ovf(dst_ovf),
        .chan_en(chan_en), .irq_done(irq_done), .irq_esc(irq_esc)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = CNT_W'(d);
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = int'(reg_rdata);
        @(negedge clk);
        reg_rd = 1'b0;
        #1;
    endtask

    task automatic pulse_done();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
        #1;
    endtask

    task automatic pulse_act();
        @(negedge clk); activate = 1'b1;
        @(negedge clk); activate = 1'b0;
        #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        int v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 0);
        rd(2'd1, v); chk("R1 stat", v, 0);
        rd(2'd2, v); chk("R1 cnt", v, 0);
        chk("R1 chan_en", chan_en, 0);
        chk("R1 irqs", {irq_done, irq_esc}, 0);

        // R12 register map readback
        wr(2'd0, 8'h7E);
        rd(2'd0, v); chk("R12 ctrl readback", v, 8'h7E);
        rd(2'd3, v); chk("R12 addr3", v, 0);
        wr(2'd0, 0);

        // R2/R3/R4 completion sweep
        for (int n = 1; n <= 5; n++) begin
            wr(2'd2, n);
            wr(2'd0, 8'h03);
            for (int k = 1; k <= n; k++) begin
                pulse_done();
                chk("R3 chan_en", chan_en, (k != n) ? 1 : 0);
                chk("R4 irq_done", irq_done, (k == n) ? 1 : 0);
                rd(2'd2, v); chk("R2 count", v, n - k);
                rd(2'd1, v); chk("R3 done flag", v & 1, (k == n) ? 1 : 0);
            end
        end

        // R2 ignored while disabled
        wr(2'd2, 3);
        pulse_done();
        rd(2'd2, v); chk("R2 disabled strobe", v, 3);

        // R9 resume clears, then R2 saturation
        wr(2'd2, 0);
        wr(2'd0, 8'h03);
        rd(2'd1, v); chk("R9 flags cleared", v, 0);
        chk("R9 chan_en", chan_en, 1);
        chk("R9 irq_done low", irq_done, 0);
        pulse_done();
        rd(2'd2, v); chk("R2 saturate", v, 0);
        rd(2'd1, v); chk("R2 no flag at zero", v, 0);

        // R4 enable gating of done irq
        wr(2'd2, 1);
        wr(2'd0, 8'h01);
        pulse_done();
        chk("R4 irq masked", irq_done, 0);
        wr(2'd0, 8'h02);
        chk("R4 irq unmasked", irq_done, 1);

        // R10 clear needs prior read
        wr(2'd1, 0);
        #1 rd(2'd1, v); chk("R10 no read no clear", v & 1, 1);
        wr(2'd1, 0);
        rd(2'd1, v); chk("R10 read then clear", v & 1, 0);
        chk("R4 irq follows clear", irq_done, 0);

        // R5..R8 cause sweep
        for (int c = 0; c < 4; c++) begin
            for (int e = 0; e < 2; e++) begin
                wr(2'd0, 1 | 4 | (e << (3 + c)));
                case (c)
                    0: begin
                        @(negedge clk); size_err = 1'b1;
                        pulse_act();
                        size_err = 1'b0;
                    end
                    1: begin
                        @(negedge clk); blk_mode = 1'b1;
                        @(negedge clk); blk_mode = 1'b0;
                        pulse_act();
                    end
                    2: begin
                        @(negedge clk); src_ovf = 1'b1;
                        @(negedge clk); src_ovf = 1'b0;
                        #1;
                    end
                    default: begin
                        @(negedge clk); dst_ovf = 1'b1;
                        @(negedge clk); dst_ovf = 1'b0;
                        #1;
                    end
                endcase
                rd(2'd1, v);
                chk(e ? "R5-7 cause sets escape" : "R8 disabled cause", (v >> 1) & 1, e);
                chk(e ? "R5-7 chan_en dropped" : "R8 chan_en kept", chan_en, 1 - e);
                chk("R4 irq_esc", irq_esc, e);
            end
        end

        // R8 activation with no cause present
        wr(2'd0, 8'h1D);
        pulse_act();
        rd(2'd1, v); chk("R8 plain activation size", v, 0);
        pulse_act();
        rd(2'd1, v); chk("R8 plain activation block", v, 0);
        chk("R8 chan_en still on", chan_en, 1);

        // R6 pending consumed by an activation with cause disabled
        @(negedge clk); blk_mode = 1'b1;
        @(negedge clk); blk_mode = 1'b0;
        wr(2'd0, 8'h05);
        pulse_act();
        wr(2'd0, 8'h15);
        pulse_act();
        rd(2'd1, v); chk("R6 pending consumed", v, 0);

        // R11 set wins against status clear and resume
        wr(2'd0, 8'h24);
        @(negedge clk); src_ovf = 1'b1;
        @(negedge clk); src_ovf = 1'b0;
        rd(2'd1, v); chk("R7 overflow while disabled", (v >> 1) & 1, 1);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = '0; src_ovf = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; src_ovf = 1'b0;
        #1 rd(2'd1, v); chk("R11 set beats clear", (v >> 1) & 1, 1);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h25; src_ovf = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; src_ovf = 1'b0;
        #1 chk("R11 chan_en after resume clash", chan_en, 0);
        rd(2'd1, v); chk("R11 set beats resume", (v >> 1) & 1, 1);
        wr(2'd1, 0);
        rd(2'd1, v); chk("R10 escape cleared after read", v, 0);

        summary();
    end

endmodule